// File: doc/BRIEF.md
# SPI Transaction Sequencer

This block runs one SPI transaction at a time under register control. Software writes a byte count and a control word. The block then clocks out that many bytes on one, two or four data lanes and assembles received bytes from the input lanes. When the last byte completes, it raises a sticky completion flag. A small register port gives access to the control word, the length word and an interrupt set made of status, enable and write-one-to-clear registers. An access to an address that has no register, or a forbidden write, latches an error flag in the same status register.

The transmit and receive byte stores sit outside the block. The block pulls a transmit byte through `tx_take_o` in the same cycle it loads that byte. It presents each received byte with a one-cycle `rx_valid_o` pulse. The serial clock idles low. Output data changes while the serial clock is low, and input is sampled on its rising edge. Bits are sent most significant first.

Top module: `spi_xact_ctrl`

## Requirements
- R1: After reset, every readable register reads zero, `sclk_o` is low, `cs_no_o` is high, `irq_o` is low and no lane is driven.
- R2: Lane mode 0 (control bits 7:5) moves one bit per serial clock on `sdo_o[0]`, most significant first. Only lane 0 is enabled, each byte takes 8 serial clocks, and input is taken from `sdi_i[1]`.
- R3: Lane mode 1 moves two bits per serial clock on lanes 1:0, with lane 1 carrying the higher bit. Each byte takes 4 serial clocks, and input is taken from `sdi_i[1:0]`.
- R4: Lane mode 2 moves four bits per serial clock on lanes 3:0, with lane 3 carrying the highest bit. Each byte takes 2 serial clocks.
- R5: Lane mode values 3 to 7 behave exactly as mode 0. The lane mode is fixed for the whole transaction once it starts.
- R6: Writing the control word (offset 0x14) with bit 0 set, while idle, starts a transaction of the length held in bits 31:16 of offset 0x18. Exactly that many bytes are moved. After the last byte, status bit 9 (offset 0x30) is set and control bit 0 reads zero.
- R7: With receive enable (control bit 9) set, each received byte appears on `rx_byte_o` with a one-cycle `rx_valid_o` pulse. The first bit sampled becomes the most significant bit. With bit 9 clear, `rx_valid_o` never pulses.
- R8: With send enable (control bit 10) clear, `tx_take_o` never pulses and `sdo_o` and `sdo_oe_o` stay zero.
- R9: A transaction with length zero sets status bit 9 without producing any serial clock.
- R10: Writing ones to offset 0x38 clears the matching status bits. A bit that is set and cleared in the same cycle ends up set.
- R11: `irq_o` is high exactly when some status bit is set whose bit is also set in the enable register (offset 0x34).
- R12: An access to an offset outside {0x14, 0x18, 0x30, 0x34, 0x38}, a write to 0x30, or a write to 0x18 while a transaction runs sets status bit 12. Such a write changes nothing else.
- R13: Writing control bit 11 aborts any transaction, stops the serial clock and clears the status register. Writing zero afterwards leaves the block idle.
- R14: With control bit 8 set, `cs_no_o` is low while a transaction runs. If control bit 12 is also set, `cs_no_o` stays low after completion until bit 12 or bit 8 is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Level-high interrupt |
| tx_byte_i | input | 8 | Next byte to transmit |
| tx_take_o | output | 1 | Transmit byte consumed this cycle |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | `rx_byte_o` holds a new byte |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_no_o | output | 1 | Chip select, active low |
| sdo_o | output | 4 | Output data lanes |
| sdo_oe_o | output | 4 | Per-lane output enable |
| sdi_i | input | 4 | Input data lanes |

## Verification
The bench builds the block with a half serial period of three system clocks, so the divider counter wraps through several values instead of ticking every cycle. The 16-bit length field is kept. With that divider, a full eight-byte single-lane transaction finishes in a few hundred cycles. This leaves room to abort a transaction in mid-byte, to collide a length write with a running transaction, and to run every lane mode end to end, including a mode code from the reserved range.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFF_CTRL = 8'h14;
  localparam logic [REG_AW-1:0] OFF_XACT = 8'h18;
  localparam logic [REG_AW-1:0] OFF_STAT = 8'h30;
  localparam logic [REG_AW-1:0] OFF_IEN  = 8'h34;
  localparam logic [REG_AW-1:0] OFF_ICLR = 8'h38;

  localparam int LEN_LSB = 16;

  localparam int ST_W    = 13;
  localparam int ST_DONE = 9;
  localparam int ST_ILL  = 12;
  localparam logic [ST_W-1:0] ST_IMPL = (ST_W'(1) << ST_DONE) | (ST_W'(1) << ST_ILL);

  localparam int CB_EN    = 0;
  localparam int CB_MODE  = 5;
  localparam int CB_SEL   = 8;
  localparam int CB_GET   = 9;
  localparam int CB_SEND  = 10;
  localparam int CB_SRST  = 11;
  localparam int CB_CONT  = 12;

  typedef enum logic [1:0] {
    LN_1 = 2'd0,
    LN_2 = 2'd1,
    LN_4 = 2'd2
  } lanes_e;

  typedef struct packed {
    logic       cont;
    logic       srst;
    logic       send;
    logic       get;
    logic       sel;
    logic [2:0] mode;
    logic       en;
  } ctrl_t;

  function automatic lanes_e decode_mode(input logic [2:0] m);
    case (m)
      3'd1:    return LN_2;
      3'd2:    return LN_4;
      default: return LN_1;
    endcase
  endfunction

endpackage

// File: rtl/spi_xact_regs.sv
module spi_xact_regs
  import spi_xact_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              start_o,
  output ctrl_t             ctrl_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              irq_o
);

  ctrl_t            ctrl_q;
  logic [LEN_W-1:0] len_q;
  logic [ST_W-1:0]  status_q, ien_q, st_set, st_clr;
  logic             start_q;
  logic             hit_ctrl, hit_xact, hit_stat, hit_ien, hit_iclr;
  logic             legal_rd, legal_wr, busy_eff, illegal, start_d;

  assign hit_ctrl = addr_i == OFF_CTRL;
  assign hit_xact = addr_i == OFF_XACT;
  assign hit_stat = addr_i == OFF_STAT;
  assign hit_ien  = addr_i == OFF_IEN;
  assign hit_iclr = addr_i == OFF_ICLR;

  assign legal_rd = hit_ctrl | hit_xact | hit_stat | hit_ien | hit_iclr;
  assign legal_wr = hit_ctrl | hit_xact | hit_ien | hit_iclr;
  assign busy_eff = busy_i | start_q;

  assign illegal = (we_i & (~legal_wr | (hit_xact & busy_eff))) | (re_i & ~legal_rd);

  // a new start is refused while one is pending or running
  assign start_d = we_i & hit_ctrl & wdata_i[CB_EN] & ~wdata_i[CB_SRST] & ~busy_eff;

  always_comb begin
    st_set          = '0;
    st_set[ST_DONE] = done_i;
    st_set[ST_ILL]  = illegal;
    st_clr          = (we_i & hit_iclr) ? wdata_i[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      len_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_d;
      if (we_i & hit_ctrl) begin
        ctrl_q.en   <= wdata_i[CB_EN] & ~wdata_i[CB_SRST];
        ctrl_q.mode <= wdata_i[CB_MODE +: 3];
        ctrl_q.sel  <= wdata_i[CB_SEL];
        ctrl_q.get  <= wdata_i[CB_GET];
        ctrl_q.send <= wdata_i[CB_SEND];
        ctrl_q.srst <= wdata_i[CB_SRST];
        ctrl_q.cont <= wdata_i[CB_CONT];
      end else if (done_i) begin
        ctrl_q.en <= 1'b0;
      end
      if (we_i & hit_xact & ~busy_eff) len_q <= wdata_i[LEN_LSB +: LEN_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      ien_q    <= '0;
    end else begin
      if (ctrl_q.srst) status_q <= '0;
      else             status_q <= ((status_q & ~st_clr) | st_set) & ST_IMPL;
      if (we_i & hit_ien) ien_q <= wdata_i[ST_W-1:0] & ST_IMPL;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL: begin
        rdata_o[CB_EN]        = ctrl_q.en;
        rdata_o[CB_MODE +: 3] = ctrl_q.mode;
        rdata_o[CB_SEL]       = ctrl_q.sel;
        rdata_o[CB_GET]       = ctrl_q.get;
        rdata_o[CB_SEND]      = ctrl_q.send;
        rdata_o[CB_SRST]      = ctrl_q.srst;
        rdata_o[CB_CONT]      = ctrl_q.cont;
      end
      OFF_XACT: rdata_o[LEN_LSB +: LEN_W] = len_q;
      OFF_STAT: rdata_o[ST_W-1:0] = status_q;
      OFF_IEN:  rdata_o[ST_W-1:0] = ien_q;
      default:  rdata_o = '0;
    endcase
  end

  assign start_o = start_q;
  assign ctrl_o  = ctrl_q;
  assign len_o   = len_q;
  assign irq_o   = |(status_q & ien_q);

  p_done_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !ctrl_q.srst |=> status_q[ST_DONE]);

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && hit_iclr && wdata_i[ST_DONE] && !done_i |=> !status_q[ST_DONE]);

  p_illegal_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && !legal_rd && !ctrl_q.srst |=> status_q[ST_ILL]);

  p_srst_clears_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.srst |=> status_q == '0);

endmodule

// File: rtl/spi_xact_shift.sv
module spi_xact_shift
  import spi_xact_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int HALF_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  lanes_e           mode_i,
  input  logic             send_i,
  input  logic             get_i,
  input  logic [7:0]       tx_byte_i,
  output logic             tx_take_o,
  output logic [7:0]       rx_byte_o,
  output logic             rx_valid_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             sclk_o,
  output logic [3:0]       sdo_o,
  output logic [3:0]       sdo_oe_o,
  input  logic [3:0]       sdi_i
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             busy_q, sclk_q, send_q, get_q, done_q, rxv_q;
  lanes_e           lanes_q;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] cnt_q;
  logic [2:0]       step_q;
  logic [7:0]       sh_q, rx_q;
  logic             tick, fall, last_step, start_ok, reload, load_now;

  function automatic logic [2:0] steps_of(input lanes_e l);
    case (l)
      LN_2:    return 3'd3;
      LN_4:    return 3'd1;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [7:0] shift_out(input lanes_e l, input logic [7:0] s);
    case (l)
      LN_2:    return {s[5:0], 2'b00};
      LN_4:    return {s[3:0], 4'b0000};
      default: return {s[6:0], 1'b0};
    endcase
  endfunction

  function automatic logic [7:0] shift_in(input lanes_e l, input logic [7:0] r,
                                          input logic [3:0] d);
    case (l)
      LN_2:    return {r[5:0], d[1:0]};
      LN_4:    return {r[3:0], d};
      default: return {r[6:0], d[1]};
    endcase
  endfunction

  assign tick      = busy_q & (div_q == DIV_LAST);
  assign fall      = tick & sclk_q;
  assign last_step = step_q == 3'd0;
  assign start_ok  = start_i & ~busy_q & ~abort_i;
  assign reload    = fall & last_step & (cnt_q != LEN_W'(1)) & ~abort_i;
  assign load_now  = (start_ok & (len_i != '0)) | reload;
  assign tx_take_o = load_now & (busy_q ? send_q : send_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      send_q  <= 1'b0;
      get_q   <= 1'b0;
      done_q  <= 1'b0;
      rxv_q   <= 1'b0;
      lanes_q <= LN_1;
      div_q   <= '0;
      cnt_q   <= '0;
      step_q  <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      rxv_q  <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
        sclk_q <= 1'b0;
        div_q  <= '0;
      end else if (!busy_q) begin
        if (start_i) begin
          if (len_i == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q  <= 1'b1;
            sclk_q  <= 1'b0;
            div_q   <= '0;
            cnt_q   <= len_i;
            lanes_q <= mode_i;
            send_q  <= send_i;
            get_q   <= get_i;
            step_q  <= steps_of(mode_i);
            sh_q    <= send_i ? tx_byte_i : 8'h00;
          end
        end
      end else if (tick) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= shift_in(lanes_q, rx_q, sdi_i);
        end else begin
          sclk_q <= 1'b0;
          if (last_step) begin
            rxv_q <= get_q;
            cnt_q <= cnt_q - LEN_W'(1);
            if (cnt_q == LEN_W'(1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              step_q <= steps_of(lanes_q);
              sh_q   <= send_q ? tx_byte_i : 8'h00;
            end
          end else begin
            step_q <= step_q - 3'd1;
            sh_q   <= shift_out(lanes_q, sh_q);
          end
        end
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  always_comb begin
    sdo_o    = '0;
    sdo_oe_o = '0;
    if (busy_q & send_q) begin
      case (lanes_q)
        LN_2: begin
          sdo_o[1:0] = sh_q[7:6];
          sdo_oe_o   = 4'b0011;
        end
        LN_4: begin
          sdo_o    = sh_q[7:4];
          sdo_oe_o = 4'b1111;
        end
        default: begin
          sdo_o[0] = sh_q[7];
          sdo_oe_o = 4'b0001;
        end
      endcase
    end
  end

  assign rx_byte_o  = rx_q;
  assign rx_valid_o = rxv_q;
  assign done_o     = done_q;
  assign busy_o     = busy_q;
  assign sclk_o     = sclk_q;

  p_idle_sclk_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);

  p_lanes_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(lanes_q));

  p_no_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !send_q |-> !tx_take_o && sdo_oe_o == 4'b0000);

  p_abort_stops_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_q && !sclk_q);

endmodule

// File: rtl/spi_xact_ctrl.sv
module spi_xact_ctrl
  import spi_xact_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  input  logic [7:0]  tx_byte_i,
  output logic        tx_take_o,
  output logic [7:0]  rx_byte_o,
  output logic        rx_valid_o,
  output logic        sclk_o,
  output logic        cs_no_o,
  output logic [3:0]  sdo_o,
  output logic [3:0]  sdo_oe_o,
  input  logic [3:0]  sdi_i
);

  ctrl_t            ctrl;
  logic [LEN_W-1:0] len;
  logic             start, busy, done, hold_q;

  spi_xact_regs #(.LEN_W(LEN_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .re_i    (reg_re_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .busy_i  (busy),
    .done_i  (done),
    .start_o (start),
    .ctrl_o  (ctrl),
    .len_o   (len),
    .irq_o   (irq_o)
  );

  spi_xact_shift #(.LEN_W(LEN_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (ctrl.srst),
    .start_i    (start),
    .len_i      (len),
    .mode_i     (decode_mode(ctrl.mode)),
    .send_i     (ctrl.send),
    .get_i      (ctrl.get),
    .tx_byte_i  (tx_byte_i),
    .tx_take_o  (tx_take_o),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o),
    .done_o     (done),
    .busy_o     (busy),
    .sclk_o     (sclk_o),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .sdi_i      (sdi_i)
  );

  // keep select asserted across transactions when continue is set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hold_q <= 1'b0;
    else if (ctrl.srst | ~ctrl.cont) hold_q <= 1'b0;
    else if (done)                   hold_q <= 1'b1;
  end

  assign cs_no_o = ~(ctrl.sel & (busy | hold_q));

  p_cs_busy_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && ctrl.sel |-> !cs_no_o);

  p_cs_hold_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && ctrl.sel && ctrl.cont && !ctrl.srst && !(reg_we_i && reg_addr_i == OFF_CTRL)
      |=> !cs_no_o);

endmodule

// File: tb/spi_xact_ctrl_test.sv
`timescale 1ns/1ps
module spi_xact_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, tx_take, rx_valid, sclk, cs_n;
  logic [7:0]  tx_byte, rx_byte;
  logic [3:0]  sdo, sdo_oe, sdi;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  spi_xact_ctrl #(.LEN_W(16), .HALF_DIV(3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .tx_byte_i(tx_byte),
    .tx_take_o(tx_take), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .sclk_o(sclk),
    .cs_no_o(cs_n), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sdi_i(sdi)
  );

  // peripheral model: monotonic counters, tasks only snapshot bases
  logic [7:0]  tx_mem [8];
  logic [7:0]  rx_got [8];
  int          tx_idx = 0, tx_base = 0, rx_n = 0, rx_base = 0;
  int          sclk_cnt = 0, fall_cnt = 0, fall_base = 0, cs_hi = 0;
  int          b_lanes = 1;
  logic [31:0] miso_pat = '0, mosi_acc = '0, miso_now;
  logic [3:0]  oe_last = '0;

  assign tx_byte = tx_mem[3'(tx_idx - tx_base)];

  always @(posedge clk) begin
    if (tx_take) tx_idx <= tx_idx + 1;
    if (rx_valid) begin
      rx_got[rx_n[2:0]] <= rx_byte;
      rx_n <= rx_n + 1;
    end
  end

  always @(posedge sclk) begin
    case (b_lanes)
      4:       mosi_acc <= {mosi_acc[27:0], sdo};
      2:       mosi_acc <= {mosi_acc[29:0], sdo[1:0]};
      default: mosi_acc <= {mosi_acc[30:0], sdo[0]};
    endcase
    sclk_cnt <= sclk_cnt + 1;
    oe_last  <= sdo_oe;
    if (cs_n) cs_hi <= cs_hi + 1;
  end

  always @(negedge sclk) fall_cnt <= fall_cnt + 1;

  always_comb begin
    miso_now = miso_pat << (b_lanes * (fall_cnt - fall_base));
    case (b_lanes)
      4:       sdi = miso_now[31:28];
      2:       sdi = {2'b00, miso_now[31:30]};
      default: sdi = {2'b00, miso_now[31], 1'b0};
    endcase
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0; addr = '0;
  endtask

  function automatic logic [31:0] ctrl_word(input int mode, input bit send, input bit get,
                                            input bit sel, input bit cont);
    return (32'(cont) << 12) | (32'(send) << 10) | (32'(get) << 9) | (32'(sel) << 8) |
           (32'(mode) << 5) | 32'h1;
  endfunction

  task automatic start_xact(input int mode, input bit send, input bit get, input bit sel,
                            input bit cont, input int len, input int lanes);
    b_lanes   = lanes;
    tx_base   = tx_idx;
    rx_base   = rx_n;
    fall_base = fall_cnt;
    wr(8'h18, 32'(len) << 16);
    wr(8'h14, ctrl_word(mode, send, get, sel, cont));
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] s;
    bit ok = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(8'h30, s);
      if (s[9]) begin ok = 1; break; end
    end
    chk({tag, " completion"}, 32'(ok), 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h14, d); chk("R1 ctrl", d, 0);
    rd(8'h18, d); chk("R1 xact", d, 0);
    rd(8'h30, d); chk("R1 status", d, 0);
    rd(8'h34, d); chk("R1 enable", d, 0);
    chk("R1 pins", {sclk, cs_n, irq, sdo_oe}, {1'b0, 1'b1, 1'b0, 4'h0});
  endtask

  task automatic t_single;
    int s0, c0;
    logic [31:0] d;
    tx_mem[0] = 8'hA5; tx_mem[1] = 8'h3C; miso_pat = 32'hC35A_0000;
    s0 = sclk_cnt; c0 = cs_hi;
    start_xact(0, 1, 1, 1, 0, 2, 1);
    wait_done("R6 single");
    chk("R2 sclk count", 32'(sclk_cnt - s0), 16);
    chk("R2 mosi bits", {16'h0, mosi_acc[15:0]}, 32'h0000_A53C);
    chk("R2 oe", {28'h0, oe_last}, 32'h1);
    chk("R6 bytes taken", 32'(tx_idx - tx_base), 2);
    chk("R7 rx count", 32'(rx_n - rx_base), 2);
    chk("R7 rx byte0", {24'h0, rx_got[3'(rx_base)]}, 32'hC3);
    chk("R7 rx byte1", {24'h0, rx_got[3'(rx_base + 1)]}, 32'h5A);
    chk("R14 cs low while busy", 32'(cs_hi - c0), 0);
    rd(8'h14, d); chk("R6 enable self-clears", {31'h0, d[0]}, 0);
    rd(8'h30, d); chk("R6 status done", d, 32'h200);
    chk("R14 cs released", {31'h0, cs_n}, 1);
    wr(8'h38, 32'h1FFF);
  endtask

  task automatic t_dual;
    int s0;
    tx_mem[0] = 8'h12; tx_mem[1] = 8'h34; tx_mem[2] = 8'h56; miso_pat = 32'h9ABC_DE00;
    s0 = sclk_cnt;
    start_xact(1, 1, 1, 1, 0, 3, 2);
    wait_done("R3 dual");
    chk("R3 sclk count", 32'(sclk_cnt - s0), 12);
    chk("R3 mosi bits", {8'h0, mosi_acc[23:0]}, 32'h0012_3456);
    chk("R3 oe", {28'h0, oe_last}, 32'h3);
    chk("R3 rx byte0", {24'h0, rx_got[3'(rx_base)]}, 32'h9A);
    chk("R3 rx byte2", {24'h0, rx_got[3'(rx_base + 2)]}, 32'hDE);
    wr(8'h38, 32'h1FFF);
  endtask

  task automatic t_quad;
    int s0;
    tx_mem[0] = 8'hF0; tx_mem[1] = 8'h0F; miso_pat = 32'h7777_7777;
    s0 = sclk_cnt;
    start_xact(2, 1, 0, 1, 0, 2, 4);
    wait_done("R4 quad");
    chk("R4 sclk count", 32'(sclk_cnt - s0), 4);
    chk("R4 mosi bits", {16'h0, mosi_acc[15:0]}, 32'h0000_F00F);
    chk("R4 oe", {28'h0, oe_last}, 32'hF);
    chk("R7 no rx when get clear", 32'(rx_n - rx_base), 0);
    wr(8'h38, 32'h1FFF);
  endtask

  task automatic t_mode7;
    int s0;
    tx_mem[0] = 8'h81; miso_pat = 32'h0;
    s0 = sclk_cnt;
    start_xact(7, 1, 0, 0, 0, 1, 1);
    wait_done("R5 reserved mode");
    chk("R5 sclk count", 32'(sclk_cnt - s0), 8);
    chk("R5 mosi bits", {24'h0, mosi_acc[7:0]}, 32'h81);
    chk("R5 oe", {28'h0, oe_last}, 32'h1);
    wr(8'h38, 32'h1FFF);
  endtask

  task automatic t_nosend;
    tx_mem[0] = 8'hFF; miso_pat = 32'h6E00_0000;
    start_xact(0, 0, 1, 1, 0, 1, 1);
    wait_done("R8 receive only");
    chk("R8 no take", 32'(tx_idx - tx_base), 0);
    chk("R8 no drive", {24'h0, oe_last, 4'h0} | {24'h0, mosi_acc[7:0]}, 0);
    chk("R7 rx only byte", {24'h0, rx_got[3'(rx_base)]}, 32'h6E);
    wr(8'h38, 32'h1FFF);
  endtask

  task automatic t_zero_irq;
    int s0;
    logic [31:0] d;
    s0 = sclk_cnt;
    start_xact(0, 1, 1, 0, 0, 0, 1);
    wait_done("R9 zero length");
    chk("R9 no sclk", 32'(sclk_cnt - s0), 0);
    chk("R11 masked", {31'h0, irq}, 0);
    wr(8'h38, 32'h1000);
    rd(8'h30, d); chk("R10 other bit clear keeps done", d, 32'h200);
    wr(8'h34, 32'h200);
    chk("R11 enabled", {31'h0, irq}, 1);
    wr(8'h38, 32'h200);
    rd(8'h30, d); chk("R10 w1c", d, 0);
    chk("R11 after clear", {31'h0, irq}, 0);
    wr(8'h34, 32'h0);
  endtask

  task automatic t_illegal;
    int s0;
    logic [31:0] d;
    wr(8'h34, 32'h1000);
    rd(8'h44, d);
    rd(8'h30, d); chk("R12 unmapped read", d, 32'h1000);
    chk("R11 error irq", {31'h0, irq}, 1);
    wr(8'h38, 32'h1000);
    wr(8'h30, 32'h0);
    rd(8'h30, d); chk("R12 status write", d, 32'h1000);
    wr(8'h38, 32'h1000);
    wr(8'h34, 32'h0);
    tx_mem[0] = 8'h11; tx_mem[1] = 8'h22; tx_mem[2] = 8'h33; tx_mem[3] = 8'h44;
    s0 = sclk_cnt;
    start_xact(0, 1, 0, 0, 0, 4, 1);
    wr(8'h18, 32'h0001_0000);
    rd(8'h18, d); chk("R12 busy length write ignored", d, 32'h0004_0000);
    wait_done("R12 busy");
    chk("R12 length kept", 32'(sclk_cnt - s0), 32);
    rd(8'h30, d); chk("R12 busy write flagged", d, 32'h1200);
    wr(8'h38, 32'h1FFF);
  endtask

  task automatic t_srst;
    int s0, s1;
    logic [31:0] d;
    wr(8'h34, 32'h1000);
    rd(8'h50, d);
    s0 = sclk_cnt;
    start_xact(0, 1, 1, 1, 0, 8, 1);
    repeat (40) @(posedge clk);
    wr(8'h14, 32'h800);
    wr(8'h14, 32'h0);
    s1 = sclk_cnt;
    chk("R13 aborted early", 32'(s1 - s0 < 64), 1);
    rd(8'h30, d); chk("R13 status cleared", d, 0);
    rd(8'h14, d); chk("R13 ctrl idle", d, 0);
    chk("R13 pins idle", {29'h0, sclk, cs_n, irq}, 32'b010);
    repeat (200) @(posedge clk);
    chk("R13 stays idle", 32'(sclk_cnt - s1), 0);
    wr(8'h34, 32'h0);
  endtask

  task automatic t_cont;
    tx_mem[0] = 8'h5A;
    start_xact(0, 1, 0, 1, 1, 1, 1);
    wait_done("R14 continue");
    #1 chk("R14 cs held", {31'h0, cs_n}, 0);
    wr(8'h14, 32'h0);
    #1 chk("R14 cs dropped", {31'h0, cs_n}, 1);
    wr(8'h38, 32'h1FFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      tx_mem[i] = '0;
      rx_got[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_single;
    t_dual;
    t_quad;
    t_mode7;
    t_nosend;
    t_zero_irq;
    t_illegal;
    t_srst;
    t_cont;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule